// File: doc/BRIEF.md
# Variable Lane Blend Execution Unit

This execution slice merges two 256-bit source vectors into one result, one 32-bit lane at a time. The top bit of the matching lane of a third vector, the selector, picks the source for each lane. The datapath does no arithmetic, so every lane value, including NaN and denormal encodings, reaches the result bit for bit.

A two-bit mode input picks one of three forms. The destructive 128-bit form uses the first source as its destination and keeps bits above 127 unchanged. The non-destructive 128-bit form blends the low four lanes and clears the upper half. The non-destructive 256-bit form blends all eight lanes. For the non-destructive forms the unit also works out which register holds the selector, using the upper nibble of an immediate byte. It raises an undefined-instruction flag for illegal encodings, and in that case it clears every lane write enable.

Outputs are registered. They update one clock after `start` and stay held between operations. `done` pulses once for each operation.

Top module: `vblend_unit`

## Requirements
- R1: For each lane i that is blended, result lane i equals `src_b` lane i when `sel_vec` bit 32*i+31 is 1, and equals `src_a` lane i when that bit is 0. No other selector bit has any effect.
- R2: Mode encoding: 0 = destructive 128-bit, 1 = non-destructive 128-bit, 2 = non-destructive 256-bit, 3 = reserved.
- R3: In mode 0, only lanes 0..3 are blended. `result[255:128]` equals `src_a[255:128]`, `lane_we` is 8'h0F, and `mask_idx` is 0.
- R4: In mode 1, lanes 0..3 are blended, `result[255:128]` is zero, and `lane_we` is 8'hFF.
- R5: In mode 2, all eight lanes are blended and `lane_we` is 8'hFF.
- R6: In modes 1 and 2, `mask_idx` equals `imm[7:4]`. `imm[3:0]` has no effect on any output.
- R7: When `mode32` is 1 in modes 1 and 2, `mask_idx[3]` is 0 and `mask_idx[2:0]` equals `imm[6:4]`.
- R8: `undef` is 1 when `wbit` is 1 in mode 1 or 2, or when the mode is 3. In mode 0, `wbit` is ignored.
- R9: While `undef` is 1, `lane_we` is 8'h00.
- R10: The outputs update on the clock edge that samples `start` = 1. `done` is high for exactly that one cycle. Without `start`, `result`, `lane_we`, `undef` and `mask_idx` hold their values.
- R11: Reset clears `result`, `lane_we`, `undef`, `mask_idx` and `done` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operation strobe |
| mode | input | 2 | Form select |
| mode32 | input | 1 | Core runs in 32-bit mode |
| wbit | input | 1 | W encoding bit |
| imm | input | 8 | Immediate byte |
| src_a | input | 256 | First source (destination in mode 0) |
| src_b | input | 256 | Second source |
| sel_vec | input | 256 | Selector vector |
| result | output | 256 | Blended result |
| lane_we | output | 8 | Per-lane write enable |
| undef | output | 1 | Undefined-instruction flag |
| mask_idx | output | 4 | Decoded selector register index |
| done | output | 1 | Result-valid pulse |

## Verification
Random vectors in every mode show whether each lane follows its own selector bit and whether the upper half is handled correctly for the chosen form. Selector lanes that hold only bit 31 (32'h80000000) show whether the top bit alone is enough to pick `src_b`. Lanes that hold every bit except bit 31 (32'h7FFFFFFF) show that the lower bits are ignored. Immediates that vary only in their low nibble, and runs with `mode32` set, test the index decode. Idle cycles between operations test that the outputs hold.

// File: rtl/vblend_unit.sv
module vblend_unit #(
  parameter int LANE_W = 32,
  parameter int LANES  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              mode,
  input  logic                    mode32,
  input  logic                    wbit,
  input  logic [7:0]              imm,
  input  logic [LANE_W*LANES-1:0] src_a,
  input  logic [LANE_W*LANES-1:0] src_b,
  input  logic [LANE_W*LANES-1:0] sel_vec,
  output logic [LANE_W*LANES-1:0] result,
  output logic [LANES-1:0]        lane_we,
  output logic                    undef,
  output logic [3:0]              mask_idx,
  output logic                    done
);
  localparam int VW   = LANE_W * LANES;
  localparam int HALF = LANES / 2;
  localparam int HW   = VW / 2;

  logic [VW-1:0]    blended, next_res;
  logic [LANES-1:0] next_we;
  logic [3:0]       next_idx;
  logic             bad;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign blended[l*LANE_W +: LANE_W] =
      sel_vec[l*LANE_W + LANE_W - 1] ? src_b[l*LANE_W +: LANE_W] : src_a[l*LANE_W +: LANE_W];
  end

  assign bad = (mode == 2'd3) || (mode != 2'd0 && wbit);

  always_comb begin
    next_res = blended;
    next_we  = '1;
    next_idx = {imm[7] & ~mode32, imm[6:4]};
    case (mode)
      2'd0: begin
        next_res = {src_a[VW-1:HW], blended[HW-1:0]};
        next_we  = {{(LANES-HALF){1'b0}}, {HALF{1'b1}}};
        next_idx = '0;
      end
      2'd1: next_res = {{HW{1'b0}}, blended[HW-1:0]};
      default: ;
    endcase
    if (bad) next_we = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      lane_we  <= '0;
      undef    <= 1'b0;
      mask_idx <= '0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result   <= next_res;
        lane_we  <= next_we;
        undef    <= bad;
        mask_idx <= next_idx;
      end
    end
  end

  AST_DONE_RISE: assert property (@(posedge clk) disable iff (!rst_n) start |=> done); // R10
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !start |=> !done); // R10
  AST_HOLD_RES: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(result)); // R10
  AST_UNDEF_NO_WE: assert property (@(posedge clk) disable iff (!rst_n) undef |-> lane_we == '0); // R9
  AST_LEGACY_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode == 2'd0 |=> result[VW-1:HW] == $past(src_a[VW-1:HW])); // R3
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode == 2'd1 |=> result[VW-1:HW] == '0); // R4
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    start && mode32 && mode != 2'd0 |=> !mask_idx[3]); // R7
endmodule

// File: tb/vblend_unit_test.sv
`timescale 1ns/1ps
module vblend_unit_test;
  logic clk = 0, rst_n = 0, start = 0, mode32 = 0, wbit = 0;
  logic [1:0] mode = 0;
  logic [7:0] imm = 0;
  logic [255:0] src_a = 0, src_b = 0, sel_vec = 0, result;
  logic [7:0] lane_we;
  logic undef, done;
  logic [3:0] mask_idx;
  int checks = 0, failures = 0;

  logic [255:0] e_res;
  logic [7:0]   e_we;
  logic         e_undef;
  logic [3:0]   e_idx;

  always #2.5 clk = ~clk;

  vblend_unit uut (.clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .mode32(mode32),
    .wbit(wbit), .imm(imm), .src_a(src_a), .src_b(src_b), .sel_vec(sel_vec),
    .result(result), .lane_we(lane_we), .undef(undef), .mask_idx(mask_idx), .done(done));

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model();
    int nl;
    nl = (mode == 2) ? 8 : 4;
    e_res = 0;
    for (int i = 0; i < 8; i++) begin
      if (i < nl) e_res[i*32 +: 32] = sel_vec[i*32+31] ? src_b[i*32 +: 32] : src_a[i*32 +: 32];
      else if (mode == 0) e_res[i*32 +: 32] = src_a[i*32 +: 32];
    end
    e_undef = (mode == 3) || (mode != 0 && wbit);
    e_we = (mode == 0) ? 8'h0F : 8'hFF;
    if (e_undef) e_we = 8'h00;
    e_idx = (mode == 0) ? 4'd0 : {imm[7] & ~mode32, imm[6:4]};
  endtask

  task automatic run(string req, logic [1:0] m, logic m32, logic w, logic [7:0] im,
                     logic [255:0] a, logic [255:0] b, logic [255:0] s);
    @(negedge clk);
    mode = m; mode32 = m32; wbit = w; imm = im; src_a = a; src_b = b; sel_vec = s; start = 1;
    model();
    @(negedge clk);
    start = 0;
    chk({req, " done"}, {255'b0, done}, 256'd1);
    if (!e_undef) chk({req, " result"}, result, e_res);
    chk({req, " lane_we"}, {248'b0, lane_we}, {248'b0, e_we});
    chk({req, " R8 undef"}, {255'b0, undef}, {255'b0, e_undef});
    chk({req, " idx"}, {252'b0, mask_idx}, {252'b0, e_idx});
    src_a = ~src_a; src_b = ~src_b; sel_vec = ~sel_vec; imm = ~imm; mode = mode ^ 2'd1;
    @(negedge clk);
    chk("R10 done low when idle", {255'b0, done}, 256'd0);
    if (!e_undef) chk("R10 result held", result, e_res);
    chk("R10 we held", {248'b0, lane_we}, {248'b0, e_we});
    chk("R10 idx held", {252'b0, mask_idx}, {252'b0, e_idx});
  endtask

  function automatic logic [255:0] rv();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset result", result, 256'd0);
    chk("R11 reset flags", {244'b0, lane_we, undef, mask_idx[2:0]}, 256'd0);
    chk("R11 reset done", {251'b0, mask_idx, done}, 256'd0);
    rst_n = 1;
    run("R1 R5 top-bit only", 2, 0, 0, 8'hA0, rv(), rv(), {4{64'h80000000_00000000}});
    run("R1 R5 low bits only", 2, 0, 0, 8'h30, rv(), rv(), {8{32'h7FFFFFFF}});
    run("R3 legacy", 0, 0, 1, 8'hF7, rv(), rv(), {4{64'h7FFFFFFF_80000000}});
    run("R4 narrow", 1, 0, 0, 8'h5C, rv(), rv(), rv());
    run("R6 low nibble A", 2, 0, 0, 8'hC0, rv(), rv(), rv());
    run("R6 low nibble B", 2, 0, 0, 8'hCF, rv(), rv(), rv());
    run("R7 mode32", 2, 1, 0, 8'hE3, rv(), rv(), rv());
    run("R7 mode32 narrow", 1, 1, 0, 8'h9A, rv(), rv(), rv());
    run("R8 R9 wbit", 2, 0, 1, 8'h40, rv(), rv(), rv());
    run("R8 R9 reserved", 3, 0, 0, 8'h10, rv(), rv(), rv());
    run("R1 nan passthru", 2, 0, 0, 8'h20, {8{32'h7FC00001}}, {8{32'h00000001}}, {8{32'hFFFFFFFF}});
    for (int k = 0; k < 40; k++)
      run("R1 R2 random", 2'($urandom_range(0, 2)), 1'($urandom), 1'($urandom & $urandom),
          8'($urandom), rv(), rv(), rv());
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule